// File: doc/BRIEF.md
# Video/CPU Shared-Memory Timing Sequencer

This block paces one character cell of a display whose frame memory is shared by a 65xx-style processor and a video serialiser. A divide-by-eight count of the dot clock splits each cell into eight steps. The first two steps belong to the video path: the video address drives memory and the processor's bus is released. The remaining six steps belong to the processor. The processor phase clock rises halfway through the cell, so the processor data bus has been valid for two whole steps before it goes high.

The block latches the fetched byte into an internal parallel-in, serial-out register. The load happens on the dot-clock edge that closes the second video step. The register then shifts one pixel out per dot, most significant bit first. Every strobe is driven straight from a flip-flop.

A build-time option replaces the 3-bit step counter with a 4-bit counter. This counter reloads binary 1000 after it reaches all ones, and it takes the load strobe from that terminal-count state. Behaviour at the ports is the same in both variants.

Top module: `vidbus_seq`

## Requirements
- R1: The step number advances by one on every rising dot-clock edge through 0..7 and wraps from 7 back to 0, so the output pattern below repeats every eight dots.
- R2: `vid_sel` is 1 and `bus_en` is 0 during steps 0 and 1 only.
- R3: `bus_en` is 1 during steps 2, 3, 4, 5, 6 and 7.
- R4: `cpu_phase` is 0 during steps 0 to 3 and 1 during steps 4 to 7, so it rises on the edge that starts step 4.
- R5: `shift_load` is 1 during step 1 and 0 during every other step.
- R6: The value on `vdata` at the rising edge that ends step 1 is captured into the shifter. Values on `vdata` at any other edge have no effect on `pixel`.
- R7: `pixel` presents bit 7 of the captured byte during step 2, then bits 6..0 during steps 3..7, 0 and 1. The next byte follows with no dropped or repeated bit.
- R8: While `rst` is 1 at a rising edge, the next cycle shows the step-0 pattern (`bus_en`=0, `vid_sel`=1, `cpu_phase`=0, `shift_load`=0) and `pixel`=0. The first cycle after `rst` falls is step 0, a video access.
- R9: The preset terminal-count counter option (PRESET_TC=1) gives a cycle-for-cycle identical output sequence to the plain counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| vdata | input | DATA_W | Byte read from the shared memory by the video path |
| bus_en | output | 1 | Processor bus enable (0 tri-states the processor) |
| vid_sel | output | 1 | Video address selected onto the shared memory |
| cpu_phase | output | 1 | Processor phase clock |
| shift_load | output | 1 | Parallel-load strobe of the pixel shifter |
| pixel | output | 1 | Serial pixel bit |

## Verification
The bench builds two instances side by side: one with the default plain 3-bit counter (PRESET_TC=0), and one with the preset 4-bit terminal-count counter (PRESET_TC=1). Both use the default eight steps and 8-bit data. Every step-table, serialisation and reset check runs against both instances. This brings the reload-at-1000 path and the offset step mapping of the option within reach of the same expectations. A reset asserted in the middle of a cell exercises the 1110 reset value of the preset counter, which differs from its 1000 reload value.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  typedef struct packed {
    logic bus_en;
    logic vid_sel;
    logic phase;
    logic load;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{bus_en: 1'b0, vid_sel: 1'b1, phase: 1'b0, load: 1'b0};

endpackage

// File: rtl/vbs_step_counter.sv
module vbs_step_counter #(
  parameter int STEPS     = 8,
  parameter int LOAD_STEP = 1,
  parameter bit PRESET_TC = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [$clog2(STEPS)-1:0] step_next,
  output logic                     load_next
);
  localparam int STEP_W = $clog2(STEPS);

  generate
    if (PRESET_TC) begin : g_preset
      // Counter runs from 1000 up to all ones and then reloads 1000.
      // The offset puts the all-ones state on LOAD_STEP.
      localparam int                  CNT_W    = STEP_W + 1;
      localparam logic [CNT_W-1:0]    PRESET   = CNT_W'(1) << STEP_W;
      localparam logic [CNT_W-1:0]    TERM     = '1;
      localparam logic [STEP_W-1:0]   OFS      = STEP_W'(LOAD_STEP + 1);
      localparam logic [CNT_W-1:0]    RST_CNT  = PRESET | CNT_W'(STEP_W'(STEPS - LOAD_STEP - 1));
      localparam logic [CNT_W-1:0]    ONE      = CNT_W'(1);

      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      always_comb begin
        if (rst)                cnt_d = RST_CNT;
        else if (cnt_q == TERM) cnt_d = PRESET;
        else                    cnt_d = cnt_q + ONE;
      end

      always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
      end

      assign step_next = cnt_d[STEP_W-1:0] + OFS;
      assign load_next = (cnt_d == TERM);
    end else begin : g_binary
      localparam logic [STEP_W-1:0] ONE   = STEP_W'(1);
      localparam logic [STEP_W-1:0] LSTEP = STEP_W'(LOAD_STEP);

      logic [STEP_W-1:0] step_q;

      always_ff @(posedge clk) begin
        step_q <= step_next;
      end

      assign step_next = rst ? '0 : step_q + ONE;
      assign load_next = (step_next == LSTEP);
    end
  endgenerate

endmodule

// File: rtl/vbs_strobe_dec.sv
module vbs_strobe_dec
  import vbs_pkg::*;
#(
  parameter int STEPS     = 8,
  parameter int VID_STEPS = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(STEPS)-1:0] step_next,
  input  logic                     load_next,
  output strobe_t                  strb
);
  localparam int                STEP_W  = $clog2(STEPS);
  localparam logic [STEP_W-1:0] VID_END = STEP_W'(VID_STEPS);
  localparam logic [STEP_W-1:0] PH_STEP = STEP_W'(STEPS / 2);

  // Decode the step about to begin, so every strobe leaves a flip-flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      strb <= STROBE_IDLE;
    end else begin
      strb.vid_sel <= (step_next <  VID_END);
      strb.bus_en  <= (step_next >= VID_END);
      strb.phase   <= (step_next >= PH_STEP);
      strb.load    <= load_next;
    end
  end

endmodule

// File: rtl/vbs_pixel_shifter.sv
module vbs_pixel_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              pix
);
  logic [DATA_W-1:0] sr_q;

  // One control: capture while load is high, otherwise shift toward the MSB.
  always_ff @(posedge clk) begin
    if (rst)       sr_q <= '0;
    else if (load) sr_q <= din;
    else           sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign pix = sr_q[DATA_W-1];

endmodule

// File: rtl/vidbus_seq.sv
module vidbus_seq
  import vbs_pkg::*;
#(
  parameter int STEPS     = 8,
  parameter int VID_STEPS = 2,
  parameter int LOAD_STEP = 1,
  parameter int DATA_W    = 8,
  parameter bit PRESET_TC = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] vdata,
  output logic              bus_en,
  output logic              vid_sel,
  output logic              cpu_phase,
  output logic              shift_load,
  output logic              pixel
);
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step_next;
  logic              load_next;
  strobe_t           strb;

  vbs_step_counter #(
    .STEPS    (STEPS),
    .LOAD_STEP(LOAD_STEP),
    .PRESET_TC(PRESET_TC)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step_next(step_next),
    .load_next(load_next)
  );

  vbs_strobe_dec #(
    .STEPS    (STEPS),
    .VID_STEPS(VID_STEPS)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .step_next(step_next),
    .load_next(load_next),
    .strb     (strb)
  );

  vbs_pixel_shifter #(
    .DATA_W(DATA_W)
  ) u_shf (
    .clk (clk),
    .rst (rst),
    .load(strb.load),
    .din (vdata),
    .pix (pixel)
  );

  assign bus_en     = strb.bus_en;
  assign vid_sel    = strb.vid_sel;
  assign cpu_phase  = strb.phase;
  assign shift_load = strb.load;

endmodule

// File: rtl/vidbus_seq_chk.sv
module vidbus_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] vdata,
  input logic              bus_en,
  input logic              vid_sel,
  input logic              cpu_phase,
  input logic              shift_load,
  input logic              pixel
);
  // R8: reset forces the step-0 pattern and an empty shifter
  a_r8_reset_state: assert property (@(posedge clk)
    rst |=> (!bus_en && vid_sel && !cpu_phase && !shift_load && !pixel));

  // R5: the step after a load is the first processor step
  a_r5_load_then_cpu: assert property (@(posedge clk) disable iff (rst)
    shift_load |=> (bus_en && !vid_sel && !shift_load));

  // R6, R7: the first pixel after a load is the MSB of the sampled byte
  a_r7_msb_first: assert property (@(posedge clk) disable iff (rst)
    shift_load |=> (pixel == $past(vdata[DATA_W-1])));

  // R2: a video window lasts two steps
  a_r2_vid_window: assert property (@(posedge clk) disable iff (rst)
    $rose(vid_sel) |=> vid_sel);

  // R3: the processor owns the bus as soon as the video window ends
  a_r3_bus_handover: assert property (@(posedge clk) disable iff (rst)
    $fell(vid_sel) |-> bus_en);

  // R4: the phase clock rises only after two processor-owned steps
  a_r4_phase_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_phase) |-> (bus_en && $past(bus_en, 2)));
endmodule

bind vidbus_seq vidbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .vdata     (vdata),
  .bus_en    (bus_en),
  .vid_sel   (vid_sel),
  .cpu_phase (cpu_phase),
  .shift_load(shift_load),
  .pixel     (pixel)
);

// File: tb/tb_vidbus_seq.sv
`timescale 1ns/1ps
module tb_vidbus_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vdata = 8'h00;

  logic be_a, vs_a, ph_a, ld_a, px_a;
  logic be_b, vs_b, ph_b, ld_b, px_b;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vidbus_seq #(.PRESET_TC(1'b0)) dut (
    .clk(clk), .rst(rst), .vdata(vdata),
    .bus_en(be_a), .vid_sel(vs_a), .cpu_phase(ph_a), .shift_load(ld_a), .pixel(px_a));

  vidbus_seq #(.PRESET_TC(1'b1)) dut_tc (
    .clk(clk), .rst(rst), .vdata(vdata),
    .bus_en(be_b), .vid_sel(vs_b), .cpu_phase(ph_b), .shift_load(ld_b), .pixel(px_b));

  // Expected {bus_en, vid_sel, cpu_phase, shift_load} per step (R2 R3 R4 R5)
  localparam logic [3:0] EXP [8] = '{
    4'b0100, 4'b0101, 4'b1000, 4'b1000,
    4'b1010, 4'b1010, 4'b1010, 4'b1010};

  localparam logic [7:0] BYTES [8] = '{
    8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h6E, 8'h01, 8'h80};

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [3:0] strb_a();
    return {be_a, vs_a, ph_a, ld_a};
  endfunction

  function automatic logic [3:0] strb_b();
    return {be_b, vs_b, ph_b, ld_b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] got_a;
    logic [63:0] got_b;
    got_a = '0;
    got_b = '0;

    // R8: reset state
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset strobes plain", {4'b0, strb_a()}, {4'b0, EXP[0]});
    chk("R8 reset strobes preset", {4'b0, strb_b()}, {4'b0, EXP[0]});
    chk("R8 reset pixel", {6'b0, px_a, px_b}, 8'h00);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R9: step table over three cells
    for (int cyc = 0; cyc < 3; cyc++) begin
      for (int s = 0; s < 8; s++) begin
        chk($sformatf("R1 R2 R3 R4 R5 plain cell %0d step %0d", cyc, s),
            {4'b0, strb_a()}, {4'b0, EXP[s]});
        chk($sformatf("R9 preset cell %0d step %0d", cyc, s),
            {4'b0, strb_b()}, {4'b0, EXP[s]});
        @(negedge clk);
      end
    end

    // R6 R7: eight bytes serialised; vdata carries junk outside step 1
    vdata = 8'h5A;              // step 0
    @(negedge clk);             // step 1
    vdata = BYTES[0];
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      got_a[63-k] = px_a;
      got_b[63-k] = px_b;
      if ((k % 8) == 7 && (k / 8) < 7) vdata = BYTES[k/8 + 1];
      else                             vdata = 8'(k * 37 + 11);
    end
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R6 R7 plain byte %0d", i), got_a[63-8*i -: 8], BYTES[i]);
      chk($sformatf("R6 R7 R9 preset byte %0d", i), got_b[63-8*i -: 8], BYTES[i]);
    end

    // R8: reset in the middle of a cell (now at step 1, go to step 5)
    repeat (4) @(negedge clk);
    chk("R4 phase high at step 5", {6'b0, ph_a, ph_b}, 8'h03);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid-cell reset plain", {3'b0, strb_a(), px_a}, {3'b0, EXP[0], 1'b0});
    chk("R8 mid-cell reset preset", {3'b0, strb_b(), px_b}, {3'b0, EXP[0], 1'b0});
    rst = 1'b0;
    @(negedge clk);
    chk("R8 first cell after reset is video plain", {4'b0, strb_a()}, {4'b0, EXP[1]});
    chk("R8 R9 first cell after reset preset", {4'b0, strb_b()}, {4'b0, EXP[1]});
    vdata = 8'hC3;
    @(negedge clk);
    chk("R7 msb after reload", {6'b0, px_a, px_b}, 8'h03);
    chk("R3 bus owned at step 2", {6'b0, be_a, be_b}, 8'h03);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule